// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a three-wire link to a serially addressed RF step attenuator. A requester hands it a 3-bit device address and a 7-bit attenuation code in quarter-decibel units. The code is the wanted loss multiplied by four, so 18.25 dB is code 73. The block builds a 16-bit frame from the two fields. It shifts the frame out on a data line and a serial clock while the latch line stays low. It then pulses the latch line so that the attenuator whose strapped address matches takes the new setting.

Every electrical timing minimum of the link is given in nanoseconds and converted to whole cycles of the system clock when the block is elaborated. Each count is rounded up. Clock high time, clock low time, data setup, data hold, the overall serial clock period, the gap from the last rising clock edge to the latch, and the latch pulse width each get their own derived count. The block accepts one request at a time through a valid/ready handshake. It reports busy for the whole transfer and gives a single-cycle completion pulse.

Top module: `atnser_master`

## Requirements
- R1: While rst_n is low, and until the next accepted request, ser_clk, ser_data, ser_latch, busy and done are 0 and req_ready is 1. A reset in the middle of a frame abandons it with no further clock edges.
- R2: Frame bit positions 0 to 6 carry req_code bits 0 to 6, bit 7 is 0, bits 8 to 10 carry req_addr bits 0 to 2, and bits 11 to 15 are 0. The fields are captured in the cycle the request is accepted.
- R3: Exactly 16 rising edges of ser_clk occur per frame, and ser_data carries frame bit 0 at the first edge and bit 15 at the last.
- R4: ser_clk stays high for at least 30 ns and low for at least 30 ns, and successive rising edges are at least 100 ns apart (at 200 MHz: 6, 6 and 20 cycles).
- R5: ser_data changes only while ser_clk is low. It is stable for at least 10 ns before each rising edge and for at least 10 ns after it (2 cycles at 200 MHz).
- R6: ser_latch stays low while bits are shifted. It rises only after all 16 rising edges, at least 10 ns after the last of them.
- R7: The ser_latch pulse is at least 30 ns wide (6 cycles at 200 MHz).
- R8: req_ready is 1 only when idle, and a request is taken only when req_valid and req_ready are both 1. busy is 1 from the cycle after acceptance until ser_latch falls. A request presented while busy is ignored.
- R9: done is high for exactly one cycle, the cycle in which ser_latch has just returned low, and busy is 0 in that cycle.
- R10: Between frames ser_clk and ser_latch rest low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W (3) | Target device address |
| req_code | input | CODE_W (7) | Attenuation code, quarter-dB units |
| req_ready | output | 1 | Block idle, request can be taken |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ser_clk | output | 1 | Serial shift clock to the attenuator |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_latch | output | 1 | Latch strobe to the attenuator |

## Verification
The completion pulse of one frame and the handshake of the next can fall in adjacent cycles. The bench provokes this by holding req_valid high across the end of a frame, and changing the address and code in the very cycle done is seen. It then requires busy to rise exactly two cycles after done, and the second frame to carry the new fields intact. A request raised in the middle of shifting is also driven against the running transfer. It must leave the bits on the wire and the following idle period untouched.

// File: rtl/atnser_pkg.sv
package atnser_pkg;

   localparam int unsigned IDX_IDLE  = 0;
   localparam int unsigned IDX_LOW   = 1;
   localparam int unsigned IDX_HIGH  = 2;
   localparam int unsigned IDX_LESU  = 3;
   localparam int unsigned IDX_LATCH = 4;
   localparam int unsigned IDX_DONE  = 5;
   localparam int unsigned NUM_ST    = 6;

   // one-hot phases: each pin is a single state flop
   typedef enum logic [NUM_ST-1:0] {
      ST_IDLE  = NUM_ST'(1 << IDX_IDLE),
      ST_LOW   = NUM_ST'(1 << IDX_LOW),
      ST_HIGH  = NUM_ST'(1 << IDX_HIGH),
      ST_LESU  = NUM_ST'(1 << IDX_LESU),
      ST_LATCH = NUM_ST'(1 << IDX_LATCH),
      ST_DONE  = NUM_ST'(1 << IDX_DONE)
   } atn_state_e;

   // ceiling of a nanosecond minimum expressed in system clock cycles
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
      return (ns * mhz + 999) / 1000;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/atnser_frame.sv
module atnser_frame #(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned CODE_W  = 7,
   parameter int unsigned WORD_W  = 8,
   localparam int unsigned FRAME_W = 2 * WORD_W
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [CODE_W-1:0]  code_i,
   output logic [FRAME_W-1:0] frame_o
);

   if (CODE_W > WORD_W - 1) begin : g_bad_code
      $error("atnser_frame: CODE_W must leave the top bit of the level word free");
   end
   if (ADDR_W > WORD_W) begin : g_bad_addr
      $error("atnser_frame: ADDR_W wider than the address word");
   end

   // lower word: level code, its top bit forced low; upper word: address, zero padded
   for (genvar i = 0; i < FRAME_W; i++) begin : g_bit
      if (i < CODE_W) begin : g_code
         assign frame_o[i] = code_i[i];
      end else if (i < WORD_W) begin : g_lvl_pad
         assign frame_o[i] = 1'b0;
      end else if (i - WORD_W < ADDR_W) begin : g_addr
         assign frame_o[i] = addr_i[i-WORD_W];
      end else begin : g_addr_pad
         assign frame_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/atnser_timer.sv
module atnser_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   // a segment of N cycles is loaded with N-1 and ends on the cycle it reads zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/atnser_shifter.sv
module atnser_shifter #(
   parameter int unsigned FRAME_W = 16,
   localparam int unsigned BIT_W  = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               shift_i,
   output logic               bit_o,
   output logic               last_o
);

   logic [FRAME_W-1:0] sh_q;
   logic [BIT_W-1:0]   idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         sh_q  <= frame_i;
         idx_q <= '0;
      end else if (shift_i) begin
         sh_q  <= {1'b0, sh_q[FRAME_W-1:1]};
         idx_q <= idx_q + 1'b1;
      end
   end

   assign bit_o  = sh_q[0];
   assign last_o = (idx_q == BIT_W'(FRAME_W - 1));

endmodule

// File: rtl/atnser_master.sv
module atnser_master
   import atnser_pkg::*;
#(
   parameter int unsigned CLK_MHZ     = 200,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned CODE_W      = 7,
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned T_CLKH_NS   = 30,
   parameter int unsigned T_CLKL_NS   = 30,
   parameter int unsigned T_PERIOD_NS = 100,
   parameter int unsigned T_SU_NS     = 10,
   parameter int unsigned T_HD_NS     = 10,
   parameter int unsigned T_LESU_NS   = 10,
   parameter int unsigned T_LEPW_NS   = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CODE_W-1:0] req_code,
   output logic              req_ready,
   output logic              busy,
   output logic              done,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_latch
);

   localparam int unsigned FRAME_W  = 2 * WORD_W;
   localparam int unsigned C_CLKH   = ns_to_cyc(T_CLKH_NS, CLK_MHZ);
   localparam int unsigned C_CLKL   = ns_to_cyc(T_CLKL_NS, CLK_MHZ);
   localparam int unsigned C_PERIOD = ns_to_cyc(T_PERIOD_NS, CLK_MHZ);
   localparam int unsigned C_SU     = ns_to_cyc(T_SU_NS, CLK_MHZ);
   localparam int unsigned C_HD     = ns_to_cyc(T_HD_NS, CLK_MHZ);
   // data changes on the falling edge: high phase covers hold, low phase covers setup
   localparam int unsigned HI_CYC   = umax(1, umax(C_CLKH, C_HD));
   localparam int unsigned LO_CYC   = umax(1, umax(umax(C_CLKL, C_SU),
                                       (C_PERIOD > HI_CYC) ? C_PERIOD - HI_CYC : 0));
   localparam int unsigned LESU_CYC = umax(1, ns_to_cyc(T_LESU_NS, CLK_MHZ));
   localparam int unsigned LEPW_CYC = umax(1, ns_to_cyc(T_LEPW_NS, CLK_MHZ));
   localparam int unsigned CNT_MAX  = umax(umax(HI_CYC, LO_CYC), umax(LESU_CYC, LEPW_CYC));
   localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

   if (CLK_MHZ == 0) begin : g_bad_clk
      $error("atnser_master: CLK_MHZ must be non-zero");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("atnser_master: WORD_W too small");
   end

   atn_state_e       state_q, state_d;
   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             sh_load, sh_shift, sh_last;
   logic [FRAME_W-1:0] frame;

   atnser_frame #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W),
      .WORD_W (WORD_W)
   ) u_frame (
      .addr_i  (req_addr),
      .code_i  (req_code),
      .frame_o (frame)
   );

   atnser_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   atnser_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (sh_load),
      .frame_i (frame),
      .shift_i (sh_shift),
      .bit_o   (ser_data),
      .last_o  (sh_last)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               state_d  = ST_LOW;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(LO_CYC - 1);
               sh_load  = 1'b1;
            end
         end
         ST_LOW: begin
            if (tmr_zero) begin
               state_d  = ST_HIGH;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(HI_CYC - 1);
            end
         end
         ST_HIGH: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               if (sh_last) begin
                  state_d = ST_LESU;
                  tmr_val = CNT_W'(LESU_CYC - 1);
               end else begin
                  state_d  = ST_LOW;
                  tmr_val  = CNT_W'(LO_CYC - 1);
                  sh_shift = 1'b1;
               end
            end
         end
         ST_LESU: begin
            if (tmr_zero) begin
               state_d  = ST_LATCH;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(LEPW_CYC - 1);
            end
         end
         ST_LATCH: begin
            if (tmr_zero) begin
               state_d = ST_DONE;
            end
         end
         ST_DONE: begin
            state_d = ST_IDLE;
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign req_ready = state_q[IDX_IDLE];
   assign ser_clk   = state_q[IDX_HIGH];
   assign ser_latch = state_q[IDX_LATCH];
   assign done      = state_q[IDX_DONE];
   assign busy      = state_q[IDX_LOW] | state_q[IDX_HIGH] | state_q[IDX_LESU] | state_q[IDX_LATCH];

endmodule

// File: rtl/atnser_checker.sv
module atnser_checker #(
   parameter int unsigned HI_CYC   = 6,
   parameter int unsigned LO_CYC   = 14,
   parameter int unsigned LEPW_CYC = 6,
   parameter int unsigned FRAME_W  = 16
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic busy,
   input logic done,
   input logic ser_clk,
   input logic ser_data,
   input logic ser_latch
);

   logic [15:0] hi_run, lo_run, le_run;
   logic [7:0]  rise_cnt;
   logic        clk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run   <= '0;
         lo_run   <= '0;
         le_run   <= '0;
         rise_cnt <= '0;
         clk_q    <= 1'b0;
      end else begin
         clk_q  <= ser_clk;
         hi_run <= ser_clk ? ((hi_run == 16'hffff) ? hi_run : hi_run + 1'b1) : '0;
         lo_run <= !ser_clk ? ((lo_run == 16'hffff) ? lo_run : lo_run + 1'b1) : '0;
         le_run <= ser_latch ? ((le_run == 16'hffff) ? le_run : le_run + 1'b1) : '0;
         if (!busy) begin
            rise_cnt <= '0;
         end else if (ser_clk && !clk_q) begin
            rise_cnt <= rise_cnt + 1'b1;
         end
      end
   end

   a_r3_edge_limit: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> rise_cnt <= 8'(FRAME_W));
   a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> hi_run >= 16'(HI_CYC));
   a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> lo_run >= 16'(LO_CYC));
   a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_data));
   a_r6_latch_not_shifting: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> !ser_latch);
   a_r6_latch_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_latch) |-> rise_cnt == 8'(FRAME_W));
   a_r7_latch_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_latch) |-> le_run >= 16'(LEPW_CYC));
   a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);
   a_r8_start_by_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid && req_ready));
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_at_latch_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_latch) |-> done && !busy);
   a_r10_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser_clk && !ser_latch);

endmodule

bind atnser_master atnser_checker #(
   .HI_CYC   (HI_CYC),
   .LO_CYC   (LO_CYC),
   .LEPW_CYC (LEPW_CYC),
   .FRAME_W  (FRAME_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .busy      (busy),
   .done      (done),
   .ser_clk   (ser_clk),
   .ser_data  (ser_data),
   .ser_latch (ser_latch)
);

// File: tb/sim_atnser_master.sv
`timescale 1ns/1ps
module sim_atnser_master;

   // 200 MHz: 5 ns per cycle; minimums from the requirements in cycles
   localparam int MIN_HI   = 6;
   localparam int MIN_LO   = 6;
   localparam int MIN_PER  = 20;
   localparam int MIN_SU   = 2;
   localparam int MIN_HD   = 2;
   localparam int MIN_LESU = 2;
   localparam int MIN_LEPW = 6;
   localparam int NVEC     = 8;
   // {addr[2:0], code[6:0]}
   localparam logic [9:0] VEC [NVEC] = '{
      {3'd3, 7'd73}, {3'd0, 7'd0},  {3'd7, 7'd127}, {3'd5, 7'd1},
      {3'd2, 7'd64}, {3'd6, 7'd42}, {3'd1, 7'd85},  {3'd4, 7'd127}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_addr = '0;
   logic [6:0] req_code = '0;
   logic       req_ready, busy, done, ser_clk, ser_data, ser_latch;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   atnser_master u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_code  (req_code),
      .req_ready (req_ready),
      .busy      (busy),
      .done      (done),
      .ser_clk   (ser_clk),
      .ser_data  (ser_data),
      .ser_latch (ser_latch)
   );

   // monitor state
   int cyc = 0, rises, dones, min_hi, min_lo, min_per, min_su, min_hd, lesu_gap, le_w;
   int t_edge = 0, t_rise = 0, t_si = 0, t_le = 0, t_lefall = -1, t_done = -1, t_busy_rise = -1;
   bit le_in_shift, si_in_high, le_no_busy, done_busy;
   logic [15:0] cap;
   logic p_clk = 0, p_si = 0, p_le = 0, p_busy = 0;

   task automatic clear_stats();
      rises = 0; dones = 0; min_hi = 9999; min_lo = 9999; min_per = 9999;
      min_su = 9999; min_hd = 9999; lesu_gap = -1; le_w = -1;
      le_in_shift = 0; si_in_high = 0; le_no_busy = 0; done_busy = 0; cap = '0;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (busy && !p_busy) begin t_edge = cyc; t_si = cyc; t_busy_rise = cyc; end
      if (ser_clk && !p_clk) begin
         if (rises < 16) cap[rises] = ser_data;
         if (rises > 0 && cyc - t_rise < min_per) min_per = cyc - t_rise;
         if (cyc - t_edge < min_lo) min_lo = cyc - t_edge;
         if (cyc - t_si < min_su) min_su = cyc - t_si;
         if (ser_latch) le_in_shift = 1;
         rises++;
         t_rise = cyc; t_edge = cyc;
      end
      if (!ser_clk && p_clk) begin
         if (cyc - t_edge < min_hi) min_hi = cyc - t_edge;
         t_edge = cyc;
      end
      if (ser_data !== p_si) begin
         if (ser_clk && p_clk) si_in_high = 1;
         if (rises > 0 && cyc - t_rise < min_hd) min_hd = cyc - t_rise;
         t_si = cyc;
      end
      if (ser_latch && !p_le) begin
         lesu_gap = (rises >= 16) ? cyc - t_rise : -1;
         if (rises < 16) le_in_shift = 1;
         t_le = cyc;
      end
      if (!ser_latch && p_le) begin le_w = cyc - t_le; t_lefall = cyc; end
      if (ser_latch && !busy) le_no_busy = 1;
      if (done) begin dones++; t_done = cyc; if (busy) done_busy = 1; end
      p_clk = ser_clk; p_si = ser_data; p_le = ser_latch; p_busy = busy;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
   endtask

   task automatic wait_done();
      int n = 0;
      while (dones == 0 && n < 3000) begin tick(1); n++; end
      if (dones == 0) chk(0, "R9", "watchdog waiting for done", 0, 1);
   endtask

   task automatic start_req(input logic [2:0] a, input logic [6:0] c);
      int n = 0;
      tick(1);
      clear_stats();
      req_addr = a; req_code = c; req_valid = 1'b1;
      while (!busy && n < 100) begin tick(1); n++; end
      req_valid = 1'b0;
   endtask

   task automatic check_frame(input logic [2:0] a, input logic [6:0] c);
      logic [15:0] exp = {5'b0, a, 1'b0, c};
      chk(cap == exp, "R2", "frame captured on the wire", int'(cap), int'(exp));
      chk(rises == 16, "R3", "rising edges per frame", rises, 16);
      chk(min_hi >= MIN_HI, "R4", "min clock high cycles", min_hi, MIN_HI);
      chk(min_lo >= MIN_LO, "R4", "min clock low cycles", min_lo, MIN_LO);
      chk(min_per >= MIN_PER, "R4", "min rise-to-rise cycles", min_per, MIN_PER);
      chk(min_su >= MIN_SU && min_hd >= MIN_HD && !si_in_high, "R5", "data setup/hold",
          (min_su < min_hd) ? min_su : min_hd, MIN_SU);
      chk(!le_in_shift && lesu_gap >= MIN_LESU, "R6", "latch gap after last edge", lesu_gap, MIN_LESU);
      chk(le_w >= MIN_LEPW, "R7", "latch width cycles", le_w, MIN_LEPW);
      chk(!le_no_busy, "R8", "busy held while latch high", int'(le_no_busy), 0);
      tick(3);
      chk(dones == 1 && t_done == t_lefall && !done_busy, "R9", "done pulse count/position",
          dones, 1);
      chk(!ser_clk && !ser_latch && req_ready, "R10", "idle levels after frame",
          int'({ser_clk, ser_latch, req_ready}), 1);
   endtask

   initial begin
      #(190000 * 5);
      chk(0, "R1", "global watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [2:0] a;
      logic [6:0] c;
      int t_done_a, tb_before;
      clear_stats();
      tick(3);
      // R1: outputs during reset
      chk(!ser_clk && !ser_latch && !ser_data && !busy && !done && req_ready, "R1",
          "reset levels", int'({ser_clk, ser_latch, ser_data, busy, done, req_ready}), 1);
      rst_n = 1'b1;
      tick(5);
      chk(!busy && rises == 0 && req_ready, "R1", "idle after reset release", rises, 0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         a = VEC[v][9:7]; c = VEC[v][6:0];
         start_req(a, c);
         wait_done();
         check_frame(a, c);
      end

      // R8: request during shifting is ignored
      start_req(3'd6, 7'd21);
      while (rises < 3) tick(1);
      req_addr = 3'd1; req_code = 7'd100; req_valid = 1'b1;
      tick(5);
      req_valid = 1'b0;
      wait_done();
      chk(cap == {5'b0, 3'd6, 1'b0, 7'd21}, "R8", "frame unchanged by request while busy",
          int'(cap), int'({5'b0, 3'd6, 1'b0, 7'd21}));
      tb_before = t_busy_rise;
      clear_stats();
      tick(40);
      chk(rises == 0 && t_busy_rise == tb_before && !busy, "R8", "no transfer from ignored request",
          rises, 0);

      // back-to-back: done of one frame next to handshake of the next
      tick(1);
      clear_stats();
      req_addr = 3'd2; req_code = 7'd11; req_valid = 1'b1;
      wait_done();
      t_done_a = t_done;
      chk(cap == {5'b0, 3'd2, 1'b0, 7'd11}, "R2", "first of back-to-back pair",
          int'(cap), int'({5'b0, 3'd2, 1'b0, 7'd11}));
      clear_stats();
      req_addr = 3'd5; req_code = 7'd99;
      while (!busy) tick(1);
      req_valid = 1'b0;
      chk(t_busy_rise == t_done_a + 2, "R8", "next accept two cycles after done",
          t_busy_rise - t_done_a, 2);
      wait_done();
      check_frame(3'd5, 7'd99);

      // R1: reset in the middle of a frame
      start_req(3'd7, 7'd5);
      while (rises < 5) tick(1);
      rst_n = 1'b0;
      tick(1);
      chk(!ser_clk && !ser_latch && !ser_data && !busy && !done && req_ready, "R1",
          "levels under mid-frame reset", int'({ser_clk, ser_latch, ser_data, busy, done, req_ready}), 1);
      rst_n = 1'b1;
      clear_stats();
      tick(40);
      chk(rises == 0 && !busy && dones == 0, "R1", "abandoned frame stays silent", rises, 0);
      start_req(3'd3, 7'd73);
      wait_done();
      check_frame(3'd3, 7'd73);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule